// File: doc/BRIEF.md
# SMBus Host Transaction Sequencer

This block turns one software request into a complete SMBus host transaction at byte level. Software chooses a protocol type, a 7-bit target address, a command byte, outgoing data and a byte count, then pulses `start`. The sequencer drives a separate bit engine one primitive at a time: START, repeated START, byte write, byte read, acknowledge bit and STOP. Bus timing, arbitration and clock stretching belong to that engine.

The sequencer checks the target's acknowledge after each byte it sends. It decides ACK or NACK for each byte it receives and stores received data in a buffer the size of one block. Each protocol has its own phase order: quick command, send and receive byte, read and write byte, read and write word, process call, block write, block read, and block write with block read. They differ in where the repeated START falls and in how count bytes are handled. When the transaction ends, a one-cycle `done` pulse marks it, and two flags report a missing acknowledge or a bad count.

`wr_data` and `wr_count` must stay unchanged from `start` until `done`. The request fields are captured at `start`.

Top module: `smbus_host_seq`

## Requirements
- R1: After reset, `busy`, `done`, `err_nack`, `err_proto`, `eng_go` and `rd_count` are all 0.
- R2: Each primitive is a one-cycle `eng_go` pulse. `eng_op` codes: 0 START, 1 repeated START, 2 write `eng_wbyte`, 3 read a byte, 4 send an acknowledge bit (`eng_nack` 1 means NACK), 5 STOP. The next primitive waits for `eng_done` from the previous one. An address byte is `{target_addr, dir}`, where dir 1 means read and 0 means write.
- R3: Quick command (`proto` 0) issues START, the address with `quick_dir` as the direction bit, then STOP. No data byte is sent.
- R4: Send byte (`proto` 1) writes `command` after the write address, then STOP. Receive byte (`proto` 2) reads one byte after the read address. Read byte (4) and read word (6) send the write address and `command`, then a repeated START and the read address, then read 1 or 2 bytes. Write byte (3) writes `command` and then one data byte.
- R5: Word transfers (write word 5, read word 6) move the low byte first. `wr_data[7:0]` is the first byte sent, and `rd_data[7:0]` holds the first byte received.
- R6: Every received byte gets an ACK except the last, which gets a NACK immediately before STOP.
- R7: Block read (`proto` 9): the first byte read is a count N. N data bytes follow and are stored from `rd_data[7:0]` upward, and `rd_count` becomes N.
- R8: Block write (`proto` 8) writes `command`, then `wr_count`, then `wr_count` bytes taken from `wr_data[7:0]` upward, then STOP.
- R9: Process call (`proto` 7) writes `command` and two data bytes, then a repeated START and the read address, then reads two bytes. Block process call (`proto` 10) writes `command`, a count and the data, then a repeated START and the read address, then reads a count and that many bytes. Its counts are limited to 31.
- R10: If a target fails to acknowledge any byte the host sends, the transaction stops at once with STOP and `err_nack` is set.
- R11: A received count of 0, or above the limit (32, or 31 for block process call), gets a NACK followed by STOP. `err_proto` is set and `rd_count` stays 0.
- R12: A `start` while `busy` is ignored. It neither changes nor extends the running transaction.
- R13: `done` lasts exactly one cycle. The error flags and `rd_data`/`rd_count` then hold until the next accepted `start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a transaction (accepted only while idle) |
| proto | input | 4 | Protocol type code |
| target_addr | input | 7 | Target address |
| quick_dir | input | 1 | Direction bit for quick command |
| command | input | 8 | Command byte (data byte for send byte) |
| wr_count | input | CW | Number of bytes to write in block protocols |
| wr_data | input | MAX_BYTES*8 | Outgoing bytes, byte 0 in bits 7:0 |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-cycle completion pulse |
| err_nack | output | 1 | A sent byte was not acknowledged |
| err_proto | output | 1 | A received count was out of range |
| rd_count | output | CW | Number of data bytes received |
| rd_data | output | MAX_BYTES*8 | Received bytes, byte 0 in bits 7:0 |
| eng_go | output | 1 | Primitive request pulse |
| eng_op | output | 3 | Primitive code |
| eng_wbyte | output | 8 | Byte to write |
| eng_nack | output | 1 | Acknowledge bit value for op 4 |
| eng_done | input | 1 | Primitive finished |
| eng_rbyte | input | 8 | Byte read by the engine |
| eng_acked | input | 1 | Target acknowledged the written byte |

## Verification
The assertions check on every cycle that `done` is a single-cycle pulse that never coincides with `busy`, that primitives are never issued back to back, and that the two error flags are never set together. They also check that a finished STOP is always followed by `done`, that buffer writes stay in range, and that the receive buffer holds still while the block is idle. Only the bench scenarios can show that each protocol yields the right order of primitives and bytes, and that the acknowledge decisions fall on the right bytes. The same applies to the handling of an abort on a missing ACK or a bad count, and to a `start` issued mid-transaction leaving the primitive stream unchanged.

// File: rtl/smbus_seq_pkg.sv
package smbus_seq_pkg;

    typedef enum logic [3:0] {
        P_QUICK  = 4'd0,
        P_SEND   = 4'd1,
        P_RECV   = 4'd2,
        P_WBYTE  = 4'd3,
        P_RBYTE  = 4'd4,
        P_WWORD  = 4'd5,
        P_RWORD  = 4'd6,
        P_PCALL  = 4'd7,
        P_BWRITE = 4'd8,
        P_BREAD  = 4'd9,
        P_BPCALL = 4'd10
    } proto_e;

    typedef enum logic [2:0] {
        OP_START  = 3'd0,
        OP_RSTART = 3'd1,
        OP_WRITE  = 3'd2,
        OP_READ   = 3'd3,
        OP_ACK    = 3'd4,
        OP_STOP   = 3'd5
    } eng_op_e;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_START,
        ST_ADDR1,
        ST_CMD,
        ST_WCNT,
        ST_WDATA,
        ST_RSTART,
        ST_ADDR2,
        ST_RCNT,
        ST_RCNT_ACK,
        ST_RDATA,
        ST_RDATA_ACK,
        ST_STOP
    } phase_e;

    typedef struct packed {
        proto_e     proto;
        logic [6:0] addr;
        logic       dir1;
        logic [7:0] cmd;
    } req_t;

    function automatic logic [1:0] fixed_wr_len(proto_e p);
        case (p)
            P_WBYTE:          return 2'd1;
            P_WWORD, P_PCALL: return 2'd2;
            default:          return 2'd0;
        endcase
    endfunction

    function automatic logic [1:0] fixed_rd_len(proto_e p);
        case (p)
            P_RECV, P_RBYTE:  return 2'd1;
            P_RWORD, P_PCALL: return 2'd2;
            default:          return 2'd0;
        endcase
    endfunction

    function automatic logic is_block_wr(proto_e p);
        return (p == P_BWRITE) || (p == P_BPCALL);
    endfunction

    function automatic logic is_block_rd(proto_e p);
        return (p == P_BREAD) || (p == P_BPCALL);
    endfunction

    function automatic logic needs_rstart(proto_e p);
        return (p == P_RBYTE) || (p == P_RWORD) || (p == P_PCALL) || is_block_rd(p);
    endfunction

    function automatic int count_limit(proto_e p, int max_bytes);
        return (p == P_BPCALL) ? max_bytes - 1 : max_bytes;
    endfunction

endpackage

// File: rtl/smbus_seq_txmux.sv
module smbus_seq_txmux
    import smbus_seq_pkg::*;
#(
    parameter int MAX_BYTES = 32,
    parameter int CW        = $clog2(MAX_BYTES + 1)
) (
    input  phase_e                   phase,
    input  req_t                     req,
    input  logic [CW-1:0]            wcount,
    input  logic [CW-1:0]            idx,
    input  logic [MAX_BYTES*8-1:0]   wr_data,
    output logic [7:0]               tx_byte
);
    localparam int IW = (MAX_BYTES > 1) ? $clog2(MAX_BYTES) : 1;

    logic [7:0] data_byte;
    logic [IW-1:0] sel;

    assign sel       = IW'(idx);
    assign data_byte = wr_data[sel*8 +: 8];

    always_comb begin
        case (phase)
            ST_ADDR1: tx_byte = {req.addr, req.dir1};
            ST_ADDR2: tx_byte = {req.addr, 1'b1};
            ST_CMD:   tx_byte = req.cmd;
            ST_WCNT:  tx_byte = 8'(wcount);
            ST_WDATA: tx_byte = data_byte;
            default:  tx_byte = 8'h00;
        endcase
    end
endmodule

// File: rtl/smbus_seq_rxbuf.sv
module smbus_seq_rxbuf #(
    parameter int MAX_BYTES = 32,
    parameter int CW        = $clog2(MAX_BYTES + 1)
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     clear,
    input  logic                     wr_en,
    input  logic [CW-1:0]            wr_idx,
    input  logic [7:0]               wr_byte,
    output logic [MAX_BYTES*8-1:0]   data,
    output logic [CW-1:0]            count
);
    for (genvar g = 0; g < MAX_BYTES; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst || clear) begin
                data[g*8 +: 8] <= 8'h00;
            end else if (wr_en && (wr_idx == CW'(g))) begin
                data[g*8 +: 8] <= wr_byte;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            count <= '0;
        end else if (wr_en) begin
            count <= wr_idx + 1'b1;
        end
    end

    a_r7_idx_in_range: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> (wr_idx < CW'(MAX_BYTES)));
endmodule

// File: rtl/smbus_seq_ctrl.sv
module smbus_seq_ctrl
    import smbus_seq_pkg::*;
#(
    parameter int MAX_BYTES = 32,
    parameter int CW        = $clog2(MAX_BYTES + 1)
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           start,
    input  logic [3:0]     proto,
    input  logic [6:0]     target_addr,
    input  logic           quick_dir,
    input  logic [7:0]     command,
    input  logic [CW-1:0]  wr_count,
    output logic           busy,
    output logic           done,
    output logic           err_nack,
    output logic           err_proto,
    output phase_e         phase,
    output req_t           req,
    output logic [CW-1:0]  wcount,
    output logic [CW-1:0]  idx,
    output logic           rx_clear,
    output logic           rx_we,
    output logic           eng_go,
    output eng_op_e        eng_op,
    output logic           eng_nack,
    input  logic           eng_done,
    input  logic [7:0]     eng_rbyte,
    input  logic           eng_acked
);
    logic          pend;
    logic [CW-1:0] nbytes;
    logic          bad_cnt;
    logic          accept;
    logic          step;
    logic          last;
    proto_e        p_in;
    logic [CW-1:0] wr_lim;

    assign accept   = start && !busy;
    assign step     = pend && eng_done;
    assign last     = (idx == nbytes - 1'b1);
    assign rx_clear = accept;
    assign rx_we    = (phase == ST_RDATA) && step;
    assign p_in     = (proto > 4'd10) ? P_QUICK : proto_e'(proto);
    assign wr_lim   = CW'(count_limit(p_in, MAX_BYTES));

    always_comb begin
        case (phase)
            ST_START:                 eng_op = OP_START;
            ST_RSTART:                eng_op = OP_RSTART;
            ST_RCNT, ST_RDATA:        eng_op = OP_READ;
            ST_RCNT_ACK, ST_RDATA_ACK: eng_op = OP_ACK;
            ST_STOP:                  eng_op = OP_STOP;
            default:                  eng_op = OP_WRITE;
        endcase
        eng_nack = (phase == ST_RCNT_ACK) ? bad_cnt :
                   (phase == ST_RDATA_ACK) ? last : 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase     <= ST_IDLE;
            busy      <= 1'b0;
            done      <= 1'b0;
            err_nack  <= 1'b0;
            err_proto <= 1'b0;
            pend      <= 1'b0;
            eng_go    <= 1'b0;
            idx       <= '0;
            nbytes    <= '0;
            bad_cnt   <= 1'b0;
            wcount    <= '0;
            req       <= '0;
        end else begin
            eng_go <= 1'b0;
            done   <= 1'b0;
            if (phase == ST_IDLE) begin
                if (accept) begin
                    req.proto <= p_in;
                    req.addr  <= target_addr;
                    req.cmd   <= command;
                    req.dir1  <= (p_in == P_QUICK) ? quick_dir : (p_in == P_RECV);
                    wcount    <= (wr_count > wr_lim) ? wr_lim : wr_count;
                    busy      <= 1'b1;
                    err_nack  <= 1'b0;
                    err_proto <= 1'b0;
                    pend      <= 1'b0;
                    phase     <= ST_START;
                end
            end else if (!pend) begin
                eng_go <= 1'b1;
                pend   <= 1'b1;
            end else if (eng_done) begin
                pend <= 1'b0;
                case (phase)
                    ST_START: phase <= ST_ADDR1;
                    ST_ADDR1: begin
                        if (!eng_acked) begin
                            err_nack <= 1'b1;
                            phase    <= ST_STOP;
                        end else if (req.proto == P_QUICK) begin
                            phase <= ST_STOP;
                        end else if (req.proto == P_RECV) begin
                            idx    <= '0;
                            nbytes <= CW'(1);
                            phase  <= ST_RDATA;
                        end else begin
                            phase <= ST_CMD;
                        end
                    end
                    ST_CMD: begin
                        if (!eng_acked) begin
                            err_nack <= 1'b1;
                            phase    <= ST_STOP;
                        end else if (req.proto == P_SEND) begin
                            phase <= ST_STOP;
                        end else if (is_block_wr(req.proto)) begin
                            phase <= ST_WCNT;
                        end else if (fixed_wr_len(req.proto) != 2'd0) begin
                            idx    <= '0;
                            nbytes <= CW'(fixed_wr_len(req.proto));
                            phase  <= ST_WDATA;
                        end else begin
                            phase <= ST_RSTART;
                        end
                    end
                    ST_WCNT: begin
                        if (!eng_acked) begin
                            err_nack <= 1'b1;
                            phase    <= ST_STOP;
                        end else if (wcount == '0) begin
                            phase <= needs_rstart(req.proto) ? ST_RSTART : ST_STOP;
                        end else begin
                            idx    <= '0;
                            nbytes <= wcount;
                            phase  <= ST_WDATA;
                        end
                    end
                    ST_WDATA: begin
                        if (!eng_acked) begin
                            err_nack <= 1'b1;
                            phase    <= ST_STOP;
                        end else if (last) begin
                            phase <= needs_rstart(req.proto) ? ST_RSTART : ST_STOP;
                        end else begin
                            idx <= idx + 1'b1;
                        end
                    end
                    ST_RSTART: phase <= ST_ADDR2;
                    ST_ADDR2: begin
                        if (!eng_acked) begin
                            err_nack <= 1'b1;
                            phase    <= ST_STOP;
                        end else if (is_block_rd(req.proto)) begin
                            phase <= ST_RCNT;
                        end else begin
                            idx    <= '0;
                            nbytes <= CW'(fixed_rd_len(req.proto));
                            phase  <= ST_RDATA;
                        end
                    end
                    ST_RCNT: begin
                        bad_cnt <= (eng_rbyte == 8'd0) ||
                                   (eng_rbyte > 8'(count_limit(req.proto, MAX_BYTES)));
                        nbytes  <= CW'(eng_rbyte);
                        phase   <= ST_RCNT_ACK;
                    end
                    ST_RCNT_ACK: begin
                        if (bad_cnt) begin
                            err_proto <= 1'b1;
                            phase     <= ST_STOP;
                        end else begin
                            idx   <= '0;
                            phase <= ST_RDATA;
                        end
                    end
                    ST_RDATA: phase <= ST_RDATA_ACK;
                    ST_RDATA_ACK: begin
                        if (last) begin
                            phase <= ST_STOP;
                        end else begin
                            idx   <= idx + 1'b1;
                            phase <= ST_RDATA;
                        end
                    end
                    ST_STOP: begin
                        phase <= ST_IDLE;
                        busy  <= 1'b0;
                        done  <= 1'b1;
                    end
                    default: phase <= ST_STOP;
                endcase
            end
        end
    end

    // R13: completion is a single-cycle pulse
    a_r13_done_pulse: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);
    a_r13_done_idle: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);
    // R2: one primitive in flight at a time
    a_r2_go_spaced: assert property (@(posedge clk) disable iff (rst)
        eng_go |=> !eng_go);
    // R3: a finished STOP always ends the transaction
    a_r3_stop_ends: assert property (@(posedge clk) disable iff (rst)
        (step && eng_op == OP_STOP) |=> done);
    // R10/R11: one abort cause per transaction
    a_r10_err_excl: assert property (@(posedge clk) disable iff (rst)
        !(err_nack && err_proto));
    // R12: a start during a transaction does not end it
    a_r12_start_busy: assert property (@(posedge clk) disable iff (rst)
        (busy && start && !step) |=> busy);
endmodule

// File: rtl/smbus_host_seq.sv
module smbus_host_seq
    import smbus_seq_pkg::*;
#(
    parameter int MAX_BYTES = 32,
    parameter int CW        = $clog2(MAX_BYTES + 1)
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     start,
    input  logic [3:0]               proto,
    input  logic [6:0]               target_addr,
    input  logic                     quick_dir,
    input  logic [7:0]               command,
    input  logic [CW-1:0]            wr_count,
    input  logic [MAX_BYTES*8-1:0]   wr_data,
    output logic                     busy,
    output logic                     done,
    output logic                     err_nack,
    output logic                     err_proto,
    output logic [CW-1:0]            rd_count,
    output logic [MAX_BYTES*8-1:0]   rd_data,
    output logic                     eng_go,
    output logic [2:0]               eng_op,
    output logic [7:0]               eng_wbyte,
    output logic                     eng_nack,
    input  logic                     eng_done,
    input  logic [7:0]               eng_rbyte,
    input  logic                     eng_acked
);
    phase_e        phase;
    req_t          req;
    eng_op_e       op_e;
    logic [CW-1:0] wcount;
    logic [CW-1:0] idx;
    logic          rx_clear;
    logic          rx_we;

    assign eng_op = op_e;

    smbus_seq_ctrl #(.MAX_BYTES(MAX_BYTES), .CW(CW)) u_ctrl (
        .clk(clk), .rst(rst), .start(start), .proto(proto),
        .target_addr(target_addr), .quick_dir(quick_dir), .command(command),
        .wr_count(wr_count), .busy(busy), .done(done), .err_nack(err_nack),
        .err_proto(err_proto), .phase(phase), .req(req), .wcount(wcount),
        .idx(idx), .rx_clear(rx_clear), .rx_we(rx_we), .eng_go(eng_go),
        .eng_op(op_e), .eng_nack(eng_nack), .eng_done(eng_done),
        .eng_rbyte(eng_rbyte), .eng_acked(eng_acked)
    );

    smbus_seq_txmux #(.MAX_BYTES(MAX_BYTES), .CW(CW)) u_txmux (
        .phase(phase), .req(req), .wcount(wcount), .idx(idx),
        .wr_data(wr_data), .tx_byte(eng_wbyte)
    );

    smbus_seq_rxbuf #(.MAX_BYTES(MAX_BYTES), .CW(CW)) u_rxbuf (
        .clk(clk), .rst(rst), .clear(rx_clear), .wr_en(rx_we),
        .wr_idx(idx), .wr_byte(eng_rbyte), .data(rd_data), .count(rd_count)
    );

    // R13: the receive buffer holds while idle and no start arrives
    a_r13_buf_hold: assert property (@(posedge clk) disable iff (rst)
        (!busy && !start) |=> ($stable(rd_data) && $stable(rd_count)));
endmodule

// File: tb/smbus_host_seq_tb.sv
`timescale 1ns/1ps
module smbus_host_seq_tb;
    localparam int MB = 32;
    localparam int CW = 6;
    localparam logic [6:0] ADR = 7'h5A;
    localparam logic [7:0] AW = 8'hB4;
    localparam logic [7:0] AR = 8'hB5;
    localparam logic [7:0] CMD = 8'h21;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic rst, start, quick_dir;
    logic [3:0] proto;
    logic [6:0] target_addr;
    logic [7:0] command;
    logic [CW-1:0] wr_count;
    logic [MB*8-1:0] wr_data;
    logic busy, done, err_nack, err_proto;
    logic [CW-1:0] rd_count;
    logic [MB*8-1:0] rd_data;
    logic eng_go, eng_nack;
    logic [2:0] eng_op;
    logic [7:0] eng_wbyte;
    logic eng_done, eng_acked;
    logic [7:0] eng_rbyte;

    smbus_host_seq u_dut (
        .clk(clk), .rst(rst), .start(start), .proto(proto),
        .target_addr(target_addr), .quick_dir(quick_dir), .command(command),
        .wr_count(wr_count), .wr_data(wr_data), .busy(busy), .done(done),
        .err_nack(err_nack), .err_proto(err_proto), .rd_count(rd_count),
        .rd_data(rd_data), .eng_go(eng_go), .eng_op(eng_op),
        .eng_wbyte(eng_wbyte), .eng_nack(eng_nack), .eng_done(eng_done),
        .eng_rbyte(eng_rbyte), .eng_acked(eng_acked)
    );

    int checks = 0;
    int fails  = 0;

    // bus engine model acting as the target
    logic tb_clr;
    logic [7:0] resp [0:63];
    int nack_at;
    logic [2:0] log_op [0:127];
    logic [7:0] log_b  [0:127];
    int log_n, rptr, wr_seen, lat;
    logic [2:0] cur_op;

    always @(posedge clk) begin
        eng_done <= 1'b0;
        if (rst || tb_clr) begin
            log_n <= 0; rptr <= 0; wr_seen <= 0; lat <= 0;
            eng_acked <= 1'b1; eng_rbyte <= 8'h00; cur_op <= 3'd0;
        end else if (eng_go) begin
            if (log_n < 128) begin
                log_op[log_n] <= eng_op;
                log_b[log_n]  <= (eng_op == 3'd2) ? eng_wbyte :
                                 (eng_op == 3'd4) ? {7'b0, eng_nack} : 8'h00;
            end
            log_n  <= log_n + 1;
            cur_op <= eng_op;
            lat    <= 2;
        end else if (lat > 0) begin
            lat <= lat - 1;
            if (lat == 1) begin
                eng_done  <= 1'b1;
                eng_acked <= 1'b1;
                if (cur_op == 3'd3) begin
                    eng_rbyte <= resp[rptr % 64];
                    rptr <= rptr + 1;
                end
                if (cur_op == 3'd2) begin
                    eng_acked <= (wr_seen != nack_at);
                    wr_seen <= wr_seen + 1;
                end
            end
        end
    end

    logic [2:0] exp_op [0:127];
    logic [7:0] exp_b  [0:127];
    int exp_n;

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic ex(input logic [2:0] op, input logic [7:0] b);
        exp_op[exp_n] = op; exp_b[exp_n] = b; exp_n++;
    endtask
    task automatic exw(input logic [7:0] b); ex(3'd2, b); endtask
    task automatic exr(input logic nk); ex(3'd3, 8'h00); ex(3'd4, {7'b0, nk}); endtask

    task automatic check_log(input string req);
        int bad = -1;
        chk(req, "primitive count", log_n, exp_n);
        for (int i = 0; i < exp_n && i < log_n; i++)
            if (bad < 0 && (log_op[i] !== exp_op[i] || log_b[i] !== exp_b[i])) bad = i;
        if (bad >= 0) chk(req, "primitive entry", {log_op[bad], log_b[bad]}, {exp_op[bad], exp_b[bad]});
        else chk(req, "primitive sequence", 0, 0);
    endtask

    task automatic begin_scn();
        @(negedge clk); tb_clr = 1'b1; exp_n = 0; nack_at = -1;
        @(negedge clk); tb_clr = 1'b0;
    endtask

    task automatic run(input logic [3:0] p, input logic d, input logic [7:0] c, input int wc);
        int n = 0;
        @(negedge clk);
        proto = p; target_addr = ADR; quick_dir = d; command = c; wr_count = CW'(wc);
        start = 1'b1;
        @(negedge clk); start = 1'b0;
        while (!done && n < 3000) begin @(negedge clk); n++; end
        chk("R13", "done seen", done, 1'b1);
    endtask

    task automatic after_done();
        @(negedge clk);
        chk("R13", "done one cycle", done, 1'b0);
    endtask

    function automatic logic [7:0] rb(input int i);
        return rd_data[i*8 +: 8];
    endfunction

    task automatic t_reset();
        chk("R1", "busy", busy, 0); chk("R1", "done", done, 0);
        chk("R1", "errors", {err_nack, err_proto}, 0);
        chk("R1", "eng_go", eng_go, 0); chk("R1", "rd_count", rd_count, 0);
    endtask

    task automatic t_quick();
        begin_scn(); ex(0, 0); exw(AR); ex(5, 0);
        run(4'd0, 1'b1, CMD, 0);
        chk("R3", "errors", {err_nack, err_proto}, 0); after_done();
        check_log("R3");
    endtask

    task automatic t_send_recv();
        begin_scn(); ex(0, 0); exw(AW); exw(8'h77); ex(5, 0);
        run(4'd1, 1'b0, 8'h77, 0); after_done(); check_log("R4");
        begin_scn(); resp[0] = 8'h3C; ex(0, 0); exw(AR); exr(1); ex(5, 0);
        run(4'd2, 1'b0, CMD, 0); after_done(); check_log("R4");
        chk("R4", "recv byte", rb(0), 8'h3C); chk("R4", "recv count", rd_count, 1);
    endtask

    task automatic t_read_byte_word();
        begin_scn(); resp[0] = 8'h9E;
        ex(0, 0); exw(AW); exw(CMD); ex(1, 0); exw(AR); exr(1); ex(5, 0);
        run(4'd4, 1'b0, CMD, 0); after_done(); check_log("R4");
        chk("R4", "read byte", rb(0), 8'h9E);
        begin_scn(); resp[0] = 8'h34; resp[1] = 8'h12;
        ex(0, 0); exw(AW); exw(CMD); ex(1, 0); exw(AR); exr(0); exr(1); ex(5, 0);
        run(4'd6, 1'b0, CMD, 0); after_done(); check_log("R6");
        chk("R5", "read word low first", {rb(1), rb(0)}, 16'h1234);
    endtask

    task automatic t_write_byte_word();
        begin_scn(); wr_data = '0; wr_data[7:0] = 8'h5E;
        ex(0, 0); exw(AW); exw(CMD); exw(8'h5E); ex(5, 0);
        run(4'd3, 1'b0, CMD, 0); after_done(); check_log("R4");
        begin_scn(); wr_data[15:0] = 16'hABCD;
        ex(0, 0); exw(AW); exw(CMD); exw(8'hCD); exw(8'hAB); ex(5, 0);
        run(4'd5, 1'b0, CMD, 0); after_done(); check_log("R5");
    endtask

    task automatic t_pcall();
        begin_scn(); wr_data[15:0] = 16'h0201; resp[0] = 8'hA1; resp[1] = 8'hB2;
        ex(0, 0); exw(AW); exw(CMD); exw(8'h01); exw(8'h02); ex(1, 0); exw(AR);
        exr(0); exr(1); ex(5, 0);
        run(4'd7, 1'b0, CMD, 0); after_done(); check_log("R9");
        chk("R9", "pcall reply", {rb(1), rb(0)}, 16'hB2A1);
    endtask

    task automatic t_block_write();
        begin_scn();
        for (int i = 0; i < MB; i++) wr_data[i*8 +: 8] = 8'(8'h40 + i);
        ex(0, 0); exw(AW); exw(CMD); exw(8'd3); exw(8'h40); exw(8'h41); exw(8'h42); ex(5, 0);
        run(4'd8, 1'b0, CMD, 3); after_done(); check_log("R8");
        chk("R8", "errors", {err_nack, err_proto}, 0);
    endtask

    task automatic t_block_read(input int n);
        begin_scn(); resp[0] = 8'(n);
        for (int i = 0; i < n; i++) resp[i+1] = 8'(8'hC0 + i);
        ex(0, 0); exw(AW); exw(CMD); ex(1, 0); exw(AR); exr(0);
        for (int i = 0; i < n; i++) exr(i == n - 1);
        ex(5, 0);
        run(4'd9, 1'b0, CMD, 0); after_done(); check_log("R7");
        chk("R7", "rd_count", rd_count, n);
        chk("R7", "first byte", rb(0), 8'hC0);
        chk("R7", "last byte", rb(n - 1), 8'(8'hC0 + n - 1));
    endtask

    task automatic t_block_pcall();
        begin_scn(); wr_data[15:0] = 16'h6655; resp[0] = 8'd1; resp[1] = 8'hEE;
        ex(0, 0); exw(AW); exw(CMD); exw(8'd2); exw(8'h55); exw(8'h66);
        ex(1, 0); exw(AR); exr(0); exr(1); ex(5, 0);
        run(4'd10, 1'b0, CMD, 2); after_done(); check_log("R9");
        chk("R9", "block pcall byte", rb(0), 8'hEE); chk("R9", "count", rd_count, 1);
    endtask

    task automatic t_nack();
        begin_scn(); nack_at = 1; wr_data[7:0] = 8'h11;
        ex(0, 0); exw(AW); exw(CMD); ex(5, 0);
        run(4'd3, 1'b0, CMD, 0);
        chk("R10", "err_nack on command", err_nack, 1); chk("R10", "err_proto", err_proto, 0);
        after_done(); check_log("R10");
        chk("R13", "err_nack held", err_nack, 1);
        begin_scn(); nack_at = 0; ex(0, 0); exw(AW); ex(5, 0);
        run(4'd8, 1'b0, CMD, 3);
        chk("R10", "err_nack on address", err_nack, 1); after_done(); check_log("R10");
    endtask

    task automatic t_bad_count(input logic [3:0] p, input logic [7:0] cnt, input int wc);
        begin_scn(); resp[0] = cnt; wr_data[7:0] = 8'h99;
        ex(0, 0); exw(AW); exw(CMD);
        if (p == 4'd10) begin exw(8'(wc)); exw(8'h99); end
        ex(1, 0); exw(AR); exr(1); ex(5, 0);
        run(p, 1'b0, CMD, wc);
        chk("R11", "err_proto", err_proto, 1); chk("R11", "err_nack", err_nack, 0);
        after_done(); check_log("R11");
        chk("R11", "rd_count", rd_count, 0);
    endtask

    task automatic t_busy_start();
        int n = 0;
        int saved_n;
        logic [15:0] snap;
        begin_scn(); resp[0] = 8'd2; resp[1] = 8'h11; resp[2] = 8'h22;
        ex(0, 0); exw(AW); exw(CMD); ex(1, 0); exw(AR); exr(0); exr(0); exr(1); ex(5, 0);
        @(negedge clk);
        proto = 4'd9; target_addr = ADR; command = CMD; start = 1'b1;
        @(negedge clk); start = 1'b0;
        repeat (5) @(negedge clk);
        proto = 4'd0; target_addr = 7'h11; command = 8'hFF; start = 1'b1;
        @(negedge clk); start = 1'b0;
        repeat (20) @(negedge clk);
        start = 1'b1;
        @(negedge clk); start = 1'b0;
        while (!done && n < 3000) begin @(negedge clk); n++; end
        chk("R12", "done after busy starts", done, 1);
        check_log("R12");
        snap = {rb(1), rb(0)};
        chk("R12", "data unaffected", snap, 16'h2211);
        saved_n = log_n;
        repeat (20) @(negedge clk);
        chk("R12", "no queued transaction", log_n, saved_n);
        chk("R12", "idle afterwards", busy, 0);
        chk("R13", "buffer stable", {rb(1), rb(0)}, snap);
        chk("R13", "count stable", rd_count, 2);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        $display("FAIL watchdog expired R1 actual=hung expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks + 1, fails + 1);
        $finish;
    end

    initial begin
        rst = 1'b1; start = 1'b0; proto = 4'd0; target_addr = ADR; quick_dir = 1'b0;
        command = 8'h00; wr_count = '0; wr_data = '0; tb_clr = 1'b0; nack_at = -1; exp_n = 0;
        for (int i = 0; i < 64; i++) resp[i] = 8'h00;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_quick();
        t_send_recv();
        t_read_byte_word();
        t_write_byte_word();
        t_pcall();
        t_block_write();
        t_block_read(4);
        t_block_read(32);
        t_block_pcall();
        t_nack();
        t_bad_count(4'd9, 8'd0, 0);
        t_bad_count(4'd9, 8'd33, 0);
        t_bad_count(4'd10, 8'd32, 1);
        t_busy_start();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule